// File: doc/BRIEF.md
# Partition Table Sector Checker

This block watches a 512-byte boot sector as it arrives as 256 words of 16 bits each, low byte first, and picks the four partition descriptors out of the table near the end of the sector. A start-of-sector pulse marks where each sector begins. A word is taken on any clock edge where the valid input is high, and idle cycles may fall between words.

For each of the four slots the block publishes these fields:
- the boot indicator byte
- the partition type byte
- the 32-bit first-sector address
- the 32-bit sector count
- a flag that says whether the slot is in use

Once the last word of a sector has been taken, the block also reports whether the two-byte trailing signature was present. It pulses a done strobe in the same cycle.

A sector that is too short, or one followed by extra words, raises a length error and clears the valid flag. All published fields change only at the end of a complete sector, so a consumer can sample them on the done strobe.

Top module: `ptab_sector_checker`

## Requirements
- R1: After reset, every output is zero.
- R2: Accepted word number k (counted from 0 after the start pulse) carries sector byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Slot e (0..3) occupies bytes 446+16e to 461+16e. Slot e's fields sit at bits 8e+7:8e of boot_o and ptype_o, and at bits 32e+31:32e of start_lba_o and nsect_o.
- R3: The boot indicator is byte 0 of the slot, and the partition type is byte 4 of the slot.
- R4: The first-sector address is built from slot bytes 8..11 and the sector count from slot bytes 12..15, both little-endian (the lowest byte goes to bits 7:0).
- R5: used_o bit e is 1 exactly when at least one of the slot's 16 bytes is nonzero, including the CHS bytes at offsets 1-3 and 5-7.
- R6: All results update on the clock edge that takes word 255, and done_o is high for exactly the following cycle. At every other time the results hold their last values. A start pulse discards captures from an unfinished sector, so none of them reach a later result.
- R7: After a complete sector, tbl_valid_o is 1 exactly when byte 510 is 0x55 and byte 511 is 0xAA (word 255 equal to 0xAA55). A complete sector clears len_err_o.
- R8: A start pulse that arrives after 1 to 255 words sets len_err_o, clears tbl_valid_o, gives no done pulse and leaves the slot fields unchanged.
- R9: A word accepted after word 255 and before the next start pulse sets len_err_o and clears tbl_valid_o.
- R10: Cycles with wvalid_i low take no word, so idle gaps inside a sector do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sos_i | input | 1 | Start-of-sector pulse |
| wvalid_i | input | 1 | Word valid qualifier |
| wdata_i | input | 16 | Sector word, low byte first in stream order |
| done_o | output | 1 | One-cycle pulse when a complete sector has been published |
| tbl_valid_o | output | 1 | Signature present in the last complete sector |
| len_err_o | output | 1 | Sector length was wrong |
| used_o | output | 4 | Slot-in-use flags, bit e for slot e |
| boot_o | output | 32 | Boot indicator per slot |
| ptype_o | output | 32 | Partition type per slot |
| start_lba_o | output | 128 | First-sector address per slot |
| nsect_o | output | 128 | Sector count per slot |

## Verification
An off-by-one in the word counter moves every field by one word. This shows on the first done pulse as byte-swapped or neighbour-slot values, and the signature comparison then fails as well. A counter that is not cleared by the start pulse, or a capture that is not cleared, shows only on the next complete sector. It appears as stale address or used bits in a slot that the new sector leaves all zero. Length-tracking faults show in the cycle after the bad start pulse or the extra word, as a missing len_err_o or a valid flag that is still set.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

  localparam int unsigned SLOT_WORDS = 8;
  localparam logic [15:0] SIG_WORD = 16'hAA55;

  typedef struct packed {
    logic [7:0]  boot;
    logic [7:0]  ptype;
    logic [31:0] lba;
    logic [31:0] nsect;
    logic        used;
  } slot_t;

  function automatic logic [7:0] lo_byte(input logic [15:0] w);
    return w[7:0];
  endfunction

  function automatic logic [31:0] join_le(input logic [15:0] first_w,
                                          input logic [15:0] second_w);
    return {second_w, first_w};
  endfunction

  function automatic logic sig_ok(input logic [15:0] w);
    return w == SIG_WORD;
  endfunction

endpackage

// File: rtl/ptab_word_counter.sv
module ptab_word_counter #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned CW = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sos,
  input  logic          wvalid,
  output logic [CW-1:0] widx,
  output logic          last_evt,
  output logic          short_evt,
  output logic          extra_evt
);

  localparam logic [CW-1:0] FULL = CW'(WORDS);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt;

  assign widx      = sos ? '0 : cnt;
  assign last_evt  = wvalid && (widx == LAST);
  assign short_evt = sos && (cnt != '0) && (cnt != FULL);
  assign extra_evt = !sos && wvalid && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (sos) begin
      cnt <= wvalid ? CW'(1) : '0;
    end else if (wvalid && cnt != FULL) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/ptab_slot_capture.sv
module ptab_slot_capture
  import ptab_pkg::*;
#(
  parameter int unsigned CW = 9,
  parameter int unsigned BASE_WORD = 223
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [CW-1:0] widx,
  input  logic [15:0]   wdata,
  output slot_t         slot
);

  localparam logic [CW-1:0] BASE = CW'(BASE_WORD);

  logic [CW-1:0] offs;
  logic          hit;

  assign offs = widx - BASE;
  assign hit  = wr && (widx >= BASE) && (offs < CW'(SLOT_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (clr) begin
      slot <= '0;
    end else if (hit) begin
      slot.used <= slot.used | (wdata != 16'h0000);
      case (offs[2:0])
        3'd0: slot.boot <= lo_byte(wdata);
        3'd2: slot.ptype <= lo_byte(wdata);
        3'd4: slot.lba <= join_le(wdata, slot.lba[31:16]);
        3'd5: slot.lba <= join_le(slot.lba[15:0], wdata);
        3'd6: slot.nsect <= join_le(wdata, slot.nsect[31:16]);
        3'd7: slot.nsect <= join_le(slot.nsect[15:0], wdata);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ptab_sector_checker.sv
module ptab_sector_checker
  import ptab_pkg::*;
#(
  parameter int unsigned WORDS = 256,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned TABLE_BYTE = 446
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sos_i,
  input  logic                 wvalid_i,
  input  logic [15:0]          wdata_i,
  output logic                 done_o,
  output logic                 tbl_valid_o,
  output logic                 len_err_o,
  output logic [SLOTS-1:0]     used_o,
  output logic [SLOTS*8-1:0]   boot_o,
  output logic [SLOTS*8-1:0]   ptype_o,
  output logic [SLOTS*32-1:0]  start_lba_o,
  output logic [SLOTS*32-1:0]  nsect_o
);

  localparam int unsigned CW = $clog2(WORDS + 1);
  localparam int unsigned TABLE_WORD = TABLE_BYTE / 2;

  logic [CW-1:0] widx;
  logic          last_evt;
  logic          short_evt;
  logic          extra_evt;
  slot_t         cap [SLOTS];

  ptab_word_counter #(.WORDS(WORDS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sos       (sos_i),
    .wvalid    (wvalid_i),
    .widx      (widx),
    .last_evt  (last_evt),
    .short_evt (short_evt),
    .extra_evt (extra_evt)
  );

  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    ptab_slot_capture #(
      .CW        (CW),
      .BASE_WORD (TABLE_WORD + e * SLOT_WORDS)
    ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sos_i),
      .wr    (wvalid_i),
      .widx  (widx),
      .wdata (wdata_i),
      .slot  (cap[e])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_o[e]               <= 1'b0;
        boot_o[8*e +: 8]        <= '0;
        ptype_o[8*e +: 8]       <= '0;
        start_lba_o[32*e +: 32] <= '0;
        nsect_o[32*e +: 32]     <= '0;
      end else if (last_evt) begin
        used_o[e]               <= cap[e].used;
        boot_o[8*e +: 8]        <= cap[e].boot;
        ptype_o[8*e +: 8]       <= cap[e].ptype;
        start_lba_o[32*e +: 32] <= cap[e].lba;
        nsect_o[32*e +: 32]     <= cap[e].nsect;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      tbl_valid_o <= 1'b0;
      len_err_o   <= 1'b0;
    end else begin
      done_o <= last_evt;
      if (last_evt) begin
        tbl_valid_o <= sig_ok(wdata_i);
        len_err_o   <= 1'b0;
      end else if (short_evt || extra_evt) begin
        tbl_valid_o <= 1'b0;
        len_err_o   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ptab_sector_checker_chk.sv
module ptab_sector_checker_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [15:0]  wdata_i,
  input logic         done_o,
  input logic         tbl_valid_o,
  input logic         len_err_o,
  input logic [3:0]   used_o,
  input logic [127:0] start_lba_o,
  input logic         last_evt,
  input logic         short_evt,
  input logic         extra_evt
);

  a_r6_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> done_o);

  a_r6_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_evt));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(used_o) && $stable(start_lba_o)));

  a_r7_valid_is_sig: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tbl_valid_o == ($past(wdata_i) == 16'hAA55)));

  a_r7_done_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !len_err_o);

  a_r8_short_flags: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> (len_err_o && !tbl_valid_o && !done_o));

  a_r9_extra_flags: assert property (@(posedge clk) disable iff (!rst_n)
    extra_evt |=> (len_err_o && !tbl_valid_o));

endmodule

bind ptab_sector_checker ptab_sector_checker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wdata_i     (wdata_i),
  .done_o      (done_o),
  .tbl_valid_o (tbl_valid_o),
  .len_err_o   (len_err_o),
  .used_o      (used_o),
  .start_lba_o (start_lba_o),
  .last_evt    (last_evt),
  .short_evt   (short_evt),
  .extra_evt   (extra_evt)
);

// File: tb/ptab_sector_checker_tb.sv
module ptab_sector_checker_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sos_i = 1'b0;
  logic         wvalid_i = 1'b0;
  logic [15:0]  wdata_i = '0;
  logic         done_o, tbl_valid_o, len_err_o;
  logic [3:0]   used_o;
  logic [31:0]  boot_o, ptype_o;
  logic [127:0] start_lba_o, nsect_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] sec [512];

  always #10 clk = ~clk;

  ptab_sector_checker u_dut (
    .clk(clk), .rst_n(rst_n), .sos_i(sos_i), .wvalid_i(wvalid_i),
    .wdata_i(wdata_i), .done_o(done_o), .tbl_valid_o(tbl_valid_o),
    .len_err_o(len_err_o), .used_o(used_o), .boot_o(boot_o),
    .ptype_o(ptype_o), .start_lba_o(start_lba_o), .nsect_o(nsect_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void fill(input int seed, input logic good_sig);
    for (int i = 0; i < 512; i++) sec[i] = 8'((i * 7 + seed * 13) ^ (i >> 3));
    sec[510] = good_sig ? 8'h55 : 8'hAA;
    sec[511] = good_sig ? 8'hAA : 8'h55;
  endfunction

  function automatic void clear_slot(input int e);
    for (int b = 0; b < 16; b++) sec[446 + 16*e + b] = 8'h00;
  endfunction

  task automatic pulse_sos();
    @(negedge clk); sos_i = 1'b1; wvalid_i = 1'b0;
    @(negedge clk); sos_i = 1'b0;
  endtask

  task automatic send_words(input int n, input int gap_every);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wvalid_i = 1'b1;
      wdata_i  = {sec[2*k+1], sec[2*k]};
      if (gap_every > 0 && k % gap_every == gap_every - 1 && k != n - 1) begin
        @(negedge clk); wvalid_i = 1'b0;
      end
    end
    @(negedge clk); wvalid_i = 1'b0;
  endtask

  task automatic check_slots(input string tag);
    for (int e = 0; e < 4; e++) begin
      int b = 446 + 16*e;
      logic any = 1'b0;
      for (int j = 0; j < 16; j++) any |= (sec[b+j] != 8'h00);
      chk({tag, " R3 boot"},  boot_o[8*e +: 8],  sec[b]);
      chk({tag, " R3 type"},  ptype_o[8*e +: 8], sec[b+4]);
      chk({tag, " R4 lba"},   start_lba_o[32*e +: 32], {sec[b+11], sec[b+10], sec[b+9], sec[b+8]});
      chk({tag, " R4 nsect"}, nsect_o[32*e +: 32], {sec[b+15], sec[b+14], sec[b+13], sec[b+12]});
      chk({tag, " R5 used"},  used_o[e], any);
    end
  endtask

  task automatic t_reset();
    chk("R1 done", done_o, 0);
    chk("R1 valid", tbl_valid_o, 0);
    chk("R1 lenerr", len_err_o, 0);
    chk("R1 used", used_o, 0);
    chk("R1 fields", {boot_o, ptype_o, start_lba_o, nsect_o}, 0);
  endtask

  task automatic t_basic();
    fill(1, 1'b1);
    pulse_sos(); send_words(256, 0);
    chk("R6 done pulse", done_o, 1);
    chk("R7 valid", tbl_valid_o, 1);
    chk("R7 lenerr", len_err_o, 0);
    check_slots("R2 basic");
    @(negedge clk);
    chk("R6 done one cycle", done_o, 0);
  endtask

  task automatic t_unused_chs();
    fill(2, 1'b1);
    clear_slot(1); clear_slot(3);
    sec[446 + 16*3 + 6] = 8'h01;
    pulse_sos(); send_words(256, 0);
    chk("R5 slot1 unused", used_o[1], 0);
    chk("R5 chs-only slot3 used", used_o[3], 1);
    check_slots("R5 mixed");
  endtask

  task automatic t_bad_sig();
    fill(3, 1'b0);
    pulse_sos(); send_words(256, 0);
    chk("R7 done", done_o, 1);
    chk("R7 swapped sig invalid", tbl_valid_o, 0);
    check_slots("R7 badsig");
  endtask

  task automatic t_short_and_clear();
    logic [127:0] lba_before;
    fill(4, 1'b1);
    pulse_sos(); send_words(256, 0);
    lba_before = start_lba_o;
    fill(5, 1'b1);
    pulse_sos(); send_words(240, 0);
    chk("R6 no publish before last", start_lba_o, lba_before);
    @(negedge clk); sos_i = 1'b1;
    @(negedge clk); sos_i = 1'b0;
    chk("R8 short lenerr", len_err_o, 1);
    chk("R8 short valid", tbl_valid_o, 0);
    chk("R8 short no done", done_o, 0);
    chk("R8 fields kept", start_lba_o, lba_before);
    fill(6, 1'b1);
    for (int e = 0; e < 4; e++) clear_slot(e);
    send_words(256, 0);
    chk("R6 stale capture cleared", {used_o, start_lba_o}, 0);
    chk("R7 lenerr cleared", len_err_o, 0);
    chk("R7 valid after clean", tbl_valid_o, 1);
  endtask

  task automatic t_extra();
    fill(7, 1'b1);
    pulse_sos(); send_words(256, 0);
    chk("R9 valid before extra", tbl_valid_o, 1);
    @(negedge clk); wvalid_i = 1'b1; wdata_i = 16'h1234;
    @(negedge clk); wvalid_i = 1'b0;
    chk("R9 extra lenerr", len_err_o, 1);
    chk("R9 extra valid", tbl_valid_o, 0);
    check_slots("R9 extra");
  endtask

  task automatic t_gaps();
    fill(8, 1'b1);
    pulse_sos(); send_words(256, 5);
    chk("R10 done", done_o, 1);
    chk("R10 valid", tbl_valid_o, 1);
    check_slots("R10 gaps");
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_unused_chs();
    t_bad_sig();
    t_short_and_clear();
    t_extra();
    t_gaps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule